// File: doc/BRIEF.md
# Large-Page Sector Read Sequencer

This block fetches one 2 KB flash page as four 528-byte sectors. A single `start` pulse makes it emit the read opcode, five address bytes and the confirm opcode on a byte-cycle command stream. It then takes in each sector from the device data stream and holds it in a local sector buffer. It asks an external decoder to check the sector and forwards the sector's payload bytes. When the last sector is finished, it sends out a repacked spare area. Any Reed-Solomon arithmetic belongs to the external decoder. This block only reads the decoder's status byte, once per sector.

Three streams carry data: the command stream out, the read stream in and the output stream. Each is valid/ready. A transfer happens on a clock edge where valid and ready are both high. A source that raises valid holds it, and holds its byte, until that transfer happens. Any consumer may hold ready low for as long as it needs. The sequencer waits without losing or repeating a byte. A raw mode skips the decoder and returns every sector byte in device order. The page result is a one-cycle `done` pulse that comes with a failure flag and the largest corrected-error count.

Top module: `nprd_page_reader`

## Requirements
- R1: After `start`, the command stream carries seven bytes in this order: opcode 0x00 (`dev_is_cmd`=1), two column bytes of 0x00, page address bits 7:0, 15:8 and 23:16 (all with `dev_is_cmd`=0), then opcode 0x30 (`dev_is_cmd`=1). A byte is held stable while `dev_ready` is low.
- R2: Per sector the read stream accepts exactly 528 bytes: 512 payload bytes, then 6 free spare bytes, then 10 ECC bytes. `rd_ready` and `out_valid` are never high together. In decode mode the 512 payload bytes of each sector leave on the output stream in arrival order, sector 0 first.
- R3: In decode mode, 64 spare bytes follow the 2048 payload bytes. Spare byte s*6+j is free byte j of sector s. Spare byte 24+s*10+k is ECC byte k of sector s. `out_last` marks only the final spare byte.
- R4: The decoder status byte gives an error-present flag in bit 3 and a count-minus-one field in bits 5:4. A sector's corrected count is field+1 when bit 3 is set, and 0 otherwise. `err_max` is the largest count over the decoded sectors, at most 4, and 0 when no sector reports an error.
- R5: A status with bit 6 set (uncorrectable) ends the read at once. `fail` is 1, no further sector is requested or forwarded, and `err_max` keeps the maximum of the sectors decoded before it.
- R6: If `dec_ready` is not seen within TIMEOUT cycles after a request, the read ends with `fail`=1. A reply that arrives inside that window is accepted.
- R7: In raw mode no decode is requested. The output stream carries all 2112 bytes exactly in device order, with `out_last` on the final one, `fail`=0 and `err_max`=0.
- R8: `done` is high for exactly one cycle after the last byte or the abort, and `fail` and `err_max` are valid in that cycle. `busy` is low only while idle.
- R9: While `out_valid` is high and `out_ready` is low, `out_data` and `out_valid` are held. Output back-pressure does not change the delivered byte sequence.
- R10: In decode mode `dec_start` pulses once, for one cycle, after each sector's 528th byte is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a page read (taken while idle) |
| raw_mode | input | 1 | 1: raw read without decode, sampled with `start` |
| page_addr | input | 24 | Page (row) address, sampled with `start` |
| busy | output | 1 | Read in progress |
| dev_valid | output | 1 | Command-stream byte valid |
| dev_ready | input | 1 | Device accepts the command-stream byte |
| dev_is_cmd | output | 1 | 1: opcode cycle, 0: address cycle |
| dev_byte | output | 8 | Command or address byte |
| rd_valid | input | 1 | Device read byte valid |
| rd_ready | output | 1 | Sequencer accepts a read byte |
| rd_data | input | 8 | Device read byte |
| dec_start | output | 1 | One-cycle request to decode the buffered sector |
| dec_ready | input | 1 | Decoder result valid |
| dec_status | input | 8 | Decoder status byte |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Consumer accepts the output byte |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Final output byte of the page |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Page read failed (valid with `done`) |
| err_max | output | 3 | Largest corrected-error count (valid with `done`) |

## Verification
Every stream byte is taken on the edge where valid and ready are both high. Both signals are set up at a falling edge and stay fixed until the next rising edge. The bench therefore logs a transfer at the falling edge that comes before it, and never has to read the design at an active edge. A decoder reply driven at a falling edge is seen at the next rising edge. A reply placed d falling edges after the request is seen on wait cycle d-1, so the bench puts a reply at TIMEOUT-2 to show that an in-window reply is accepted. `done` is polled at falling edges. The status is read in the same cycle, and one cycle later the bench confirms that `done` has dropped.

// File: rtl/nprd_pkg.sv
package nprd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_FILL, ST_DREQ, ST_DWAIT, ST_DRAIN, ST_SPARE, ST_FIN
  } rd_state_t;

  // decoder status byte layout (R4, R5)
  localparam int unsigned STAT_ERR_BIT = 3;
  localparam int unsigned STAT_CNT_LSB = 4;
  localparam int unsigned STAT_BAD_BIT = 6;

  localparam logic [7:0] OP_READ  = 8'h00;
  localparam logic [7:0] OP_START = 8'h30;
endpackage

// File: rtl/nprd_cmd_issuer.sv
module nprd_cmd_issuer
  import nprd_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [ADDR_W-1:0] page,
  input  logic              dev_ready,
  output logic              dev_valid,
  output logic              dev_is_cmd,
  output logic [7:0]        dev_byte,
  output logic              finished
);
  localparam int ROW_BYTES = ADDR_W / 8;
  localparam int STEPS     = ROW_BYTES + 4;
  localparam int IDX_W     = $clog2(STEPS);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(STEPS - 1);

  logic              active;
  logic [IDX_W-1:0]  idx;
  logic [ADDR_W-1:0] page_q;
  logic [IDX_W-1:0]  row_sel;
  logic [ADDR_W-1:0] row_sh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      idx    <= '0;
      page_q <= '0;
    end else if (go) begin
      active <= 1'b1;
      idx    <= '0;
      page_q <= page;
    end else if (active && dev_ready) begin
      if (idx == LAST) active <= 1'b0;
      else             idx    <= idx + 1'b1;
    end
  end

  always_comb begin
    row_sel    = idx - IDX_W'(3);
    row_sh     = page_q >> {row_sel, 3'b000};
    dev_valid  = active;
    dev_is_cmd = 1'b0;
    dev_byte   = 8'h00;
    if (idx == '0) begin
      dev_is_cmd = 1'b1;
      dev_byte   = OP_READ;
    end else if (idx == LAST) begin
      dev_is_cmd = 1'b1;
      dev_byte   = OP_START;
    end else if (idx >= IDX_W'(3)) begin
      dev_byte   = row_sh[7:0];
    end
  end

  assign finished = active && dev_ready && (idx == LAST);
endmodule

// File: rtl/nprd_sector_buf.sv
module nprd_sector_buf #(
  parameter int DEPTH = 528,
  parameter int AW    = 10
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/nprd_spare_pack.sv
module nprd_spare_pack #(
  parameter int SECTORS = 4,
  parameter int FREE    = 6,
  parameter int ECC     = 10,
  parameter int SEC_W   = 2,
  parameter int OFF_W   = 4,
  parameter int SLOT_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [SEC_W-1:0]  sector,
  input  logic [OFF_W-1:0]  off,
  input  logic [7:0]        wdata,
  input  logic [SLOT_W-1:0] raddr,
  output logic [7:0]        rdata
);
  localparam int SLOTS = SECTORS * (FREE + ECC);

  logic [SLOT_W-1:0] wslot;
  logic [7:0]        slot_vals [SLOTS];

  // free bytes grouped first, ECC bytes grouped last, sector order kept
  always_comb begin
    if (int'(off) < FREE)
      wslot = SLOT_W'(int'(sector) * FREE + int'(off));
    else
      wslot = SLOT_W'(SECTORS * FREE + int'(sector) * ECC + int'(off) - FREE);
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic [7:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)                             q <= 8'hFF;
      else if (we && (wslot == SLOT_W'(g)))   q <= wdata;
    end
    assign slot_vals[g] = q;
  end

  assign rdata = slot_vals[raddr];
endmodule

// File: rtl/nprd_err_fold.sv
module nprd_err_fold
  import nprd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       take,
  input  logic [7:0] status,
  output logic [2:0] err_max,
  output logic       uncorr
);
  logic [2:0] sec_cnt;

  always_comb begin
    if (status[STAT_ERR_BIT])
      sec_cnt = {1'b0, status[STAT_CNT_LSB +: 2]} + 3'd1;
    else
      sec_cnt = 3'd0;
  end

  assign uncorr = status[STAT_BAD_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n || clear)            err_max <= 3'd0;
    else if (take && !uncorr && (sec_cnt > err_max)) err_max <= sec_cnt;
  end
endmodule

// File: rtl/nprd_page_reader.sv
module nprd_page_reader
  import nprd_pkg::*;
#(
  parameter int DATA_BYTES = 512,
  parameter int FREE_BYTES = 6,
  parameter int ECC_BYTES  = 10,
  parameter int SECTORS    = 4,
  parameter int TIMEOUT    = 64,
  parameter int ADDR_W     = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              raw_mode,
  input  logic [ADDR_W-1:0] page_addr,
  output logic              busy,
  output logic              dev_valid,
  input  logic              dev_ready,
  output logic              dev_is_cmd,
  output logic [7:0]        dev_byte,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [7:0]        rd_data,
  output logic              dec_start,
  input  logic              dec_ready,
  input  logic [7:0]        dec_status,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_data,
  output logic              out_last,
  output logic              done,
  output logic              fail,
  output logic [2:0]        err_max
);
  localparam int SECT_BYTES  = DATA_BYTES + FREE_BYTES + ECC_BYTES;
  localparam int SPARE_BYTES = SECTORS * (FREE_BYTES + ECC_BYTES);
  localparam int CNT_W  = $clog2(SECT_BYTES);
  localparam int SEC_W  = $clog2(SECTORS);
  localparam int OFF_W  = $clog2(FREE_BYTES + ECC_BYTES);
  localparam int SLOT_W = $clog2(SPARE_BYTES);
  localparam int TMR_W  = $clog2(TIMEOUT);
  localparam logic [CNT_W-1:0] SECT_LAST  = CNT_W'(SECT_BYTES - 1);
  localparam logic [CNT_W-1:0] DATA_LAST  = CNT_W'(DATA_BYTES - 1);
  localparam logic [CNT_W-1:0] SPARE_LAST = CNT_W'(SPARE_BYTES - 1);
  localparam logic [SEC_W-1:0] SEC_LAST   = SEC_W'(SECTORS - 1);
  localparam logic [TMR_W-1:0] TMR_LAST   = TMR_W'(TIMEOUT - 1);

  rd_state_t        state;
  logic [CNT_W-1:0] cnt;
  logic [SEC_W-1:0] sector;
  logic [TMR_W-1:0] tmr;
  logic             raw_q;
  logic             fail_q;

  logic             go;
  logic             cmd_done;
  logic             fill_hs;
  logic             spare_we;
  logic [7:0]       buf_rd;
  logic [7:0]       spare_rd;
  logic             uncorr;
  logic [CNT_W-1:0] drain_last;

  assign go         = (state == ST_IDLE) && start;
  assign fill_hs    = (state == ST_FILL) && rd_valid;
  assign spare_we   = fill_hs && (cnt >= CNT_W'(DATA_BYTES));
  assign drain_last = raw_q ? SECT_LAST : DATA_LAST;

  nprd_cmd_issuer #(.ADDR_W(ADDR_W)) u_cmd (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (go),
    .page      (page_addr),
    .dev_ready (dev_ready),
    .dev_valid (dev_valid),
    .dev_is_cmd(dev_is_cmd),
    .dev_byte  (dev_byte),
    .finished  (cmd_done)
  );

  nprd_sector_buf #(.DEPTH(SECT_BYTES), .AW(CNT_W)) u_buf (
    .clk  (clk),
    .we   (fill_hs),
    .waddr(cnt),
    .wdata(rd_data),
    .raddr(cnt),
    .rdata(buf_rd)
  );

  nprd_spare_pack #(
    .SECTORS(SECTORS), .FREE(FREE_BYTES), .ECC(ECC_BYTES),
    .SEC_W(SEC_W), .OFF_W(OFF_W), .SLOT_W(SLOT_W)
  ) u_spare (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (spare_we),
    .sector(sector),
    .off   (OFF_W'(cnt - CNT_W'(DATA_BYTES))),
    .wdata (rd_data),
    .raddr (SLOT_W'(cnt)),
    .rdata (spare_rd)
  );

  nprd_err_fold u_err (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (go),
    .take   ((state == ST_DWAIT) && dec_ready),
    .status (dec_status),
    .err_max(err_max),
    .uncorr (uncorr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      sector <= '0;
      tmr    <= '0;
      raw_q  <= 1'b0;
      fail_q <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          raw_q  <= raw_mode;
          fail_q <= 1'b0;
          state  <= ST_CMD;
        end
        ST_CMD: if (cmd_done) begin
          cnt    <= '0;
          sector <= '0;
          state  <= ST_FILL;
        end
        ST_FILL: if (rd_valid) begin
          if (cnt == SECT_LAST) begin
            cnt   <= '0;
            state <= raw_q ? ST_DRAIN : ST_DREQ;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_DREQ: begin
          tmr   <= '0;
          state <= ST_DWAIT;
        end
        ST_DWAIT: begin
          if (dec_ready) begin
            if (uncorr) begin
              fail_q <= 1'b1;
              state  <= ST_FIN;
            end else begin
              cnt   <= '0;
              state <= ST_DRAIN;
            end
          end else if (tmr == TMR_LAST) begin
            fail_q <= 1'b1;
            state  <= ST_FIN;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        ST_DRAIN: if (out_ready) begin
          if (cnt == drain_last) begin
            cnt <= '0;
            if (sector == SEC_LAST) begin
              state <= raw_q ? ST_FIN : ST_SPARE;
            end else begin
              sector <= sector + 1'b1;
              state  <= ST_FILL;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_SPARE: if (out_ready) begin
          if (cnt == SPARE_LAST) state <= ST_FIN;
          else                   cnt   <= cnt + 1'b1;
        end
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (state != ST_IDLE);
  assign rd_ready  = (state == ST_FILL);
  assign dec_start = (state == ST_DREQ);
  assign out_valid = (state == ST_DRAIN) || (state == ST_SPARE);
  assign out_data  = (state == ST_SPARE) ? spare_rd : buf_rd;
  assign out_last  = raw_q ? ((state == ST_DRAIN) && (sector == SEC_LAST) && (cnt == SECT_LAST))
                           : ((state == ST_SPARE) && (cnt == SPARE_LAST));
  assign done      = (state == ST_FIN);
  assign fail      = fail_q;
endmodule

// File: rtl/nprd_page_reader_chk.sv
module nprd_page_reader_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       dev_valid,
  input logic       dev_ready,
  input logic       dev_is_cmd,
  input logic [7:0] dev_byte,
  input logic       rd_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       dec_start,
  input logic       done,
  input logic [2:0] err_max
);
  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R1
  dev_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_valid && !dev_ready) |=> (dev_valid && $stable(dev_byte) && $stable(dev_is_cmd)));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  dec_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_start |=> !dec_start);

  // R2
  flow_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_ready && out_valid));

  // R4
  err_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (err_max <= 3'd4));
endmodule

bind nprd_page_reader nprd_page_reader_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .dev_valid (dev_valid),
  .dev_ready (dev_ready),
  .dev_is_cmd(dev_is_cmd),
  .dev_byte  (dev_byte),
  .rd_ready  (rd_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .dec_start (dec_start),
  .done      (done),
  .err_max   (err_max)
);

// File: tb/sim_nprd_page_reader.sv
`timescale 1ns/1ps
module sim_nprd_page_reader;
  localparam int TMO  = 32;
  localparam int PAGE = 2112;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic start = 1'b0, raw_mode = 1'b0;
  logic [23:0] page_addr = '0;
  logic busy, dev_valid, dev_ready, dev_is_cmd;
  logic [7:0] dev_byte;
  logic rd_valid, rd_ready;
  logic [7:0] rd_data;
  logic dec_start, dec_ready;
  logic [7:0] dec_status;
  logic out_valid, out_ready, out_last;
  logic [7:0] out_data;
  logic done, fail;
  logic [2:0] err_max;

  nprd_page_reader #(.TIMEOUT(TMO)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .raw_mode(raw_mode), .page_addr(page_addr),
    .busy(busy), .dev_valid(dev_valid), .dev_ready(dev_ready), .dev_is_cmd(dev_is_cmd),
    .dev_byte(dev_byte), .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .dec_start(dec_start), .dec_ready(dec_ready), .dec_status(dec_status),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
    .done(done), .fail(fail), .err_max(err_max)
  );

  int checks = 0, failures = 0;
  int seed = 0, cyc = 0, tcnt = 0;
  bit pend = 0, bp = 0;
  logic [7:0] got [PAGE];
  int nout = 0, nlast = 0, lastpos = -1;
  logic [8:0] cmdlog [16];
  int ncmd = 0, ndec = 0, dsec = 0;
  logic [7:0] dstat [4];
  int ddel [4];
  bit dhang [4];

  function automatic logic [7:0] pat(int t);
    return 8'((t * 13) + ((t >> 8) * 5) + seed);
  endfunction

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // device read stream
  initial begin
    rd_valid = 1'b0; rd_data = '0;
    forever begin
      @(negedge clk);
      cyc++;
      if (!rst_n) begin
        rd_valid = 1'b0; tcnt = 0; pend = 0;
      end else begin
        if (pend) tcnt++;
        if (!rd_valid || pend) rd_valid = (tcnt < PAGE) && (((tcnt + cyc) % 4) != 3);
        rd_data = pat(tcnt);
        pend = rd_valid && rd_ready;
      end
    end
  end

  // output sink and command logger
  initial begin
    out_ready = 1'b0; dev_ready = 1'b0;
    forever begin
      @(negedge clk);
      out_ready = bp ? ((cyc % 3) != 0) : 1'b1;
      dev_ready = (cyc % 2) == 0;
      if (rst_n && out_valid && out_ready) begin
        if (nout < PAGE) got[nout] = out_data;
        if (out_last) begin nlast++; lastpos = nout; end
        nout++;
      end
      if (rst_n && dev_valid && dev_ready) begin
        if (ncmd < 16) cmdlog[ncmd] = {dev_is_cmd, dev_byte};
        ncmd++;
      end
    end
  end

  // decoder model
  initial begin
    dec_ready = 1'b0; dec_status = '0;
    forever begin
      @(negedge clk);
      if (rst_n && dec_start) begin
        dsec = ndec;
        ndec++;
        if (dsec < 4 && !dhang[dsec]) begin
          repeat (ddel[dsec]) @(negedge clk);
          dec_status = dstat[dsec];
          dec_ready = 1'b1;
          @(negedge clk);
          dec_ready = 1'b0;
        end
      end
    end
  end

  task automatic do_reset(input int sd, input bit bpv);
    rst_n = 1'b0; start = 1'b0; raw_mode = 1'b0;
    seed = sd; bp = bpv;
    for (int i = 0; i < 4; i++) begin dstat[i] = 8'h00; ddel[i] = 3; dhang[i] = 0; end
    repeat (3) @(negedge clk);
    nout = 0; nlast = 0; lastpos = -1; ncmd = 0; ndec = 0;
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic run_page(input bit raw, input logic [23:0] pg, output logic [2:0] em, output bit fl);
    bit seen = 0;
    em = '0; fl = 1'b0;
    start = 1'b1; raw_mode = raw; page_addr = pg;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 30000 && !seen; i++) begin
      if (done) begin seen = 1; em = err_max; fl = fail; end
      else @(negedge clk);
    end
    chk(seen, "R8", "done seen", int'(seen), 1);
    @(negedge clk);
    chk(!done, "R8", "done one cycle", int'(done), 0);
    chk(!busy, "R8", "idle after done", int'(busy), 0);
  endtask

  task automatic check_cmds(input logic [23:0] pg);
    logic [8:0] exp [7];
    int bad = 0;
    exp[0] = {1'b1, 8'h00}; exp[1] = {1'b0, 8'h00}; exp[2] = {1'b0, 8'h00};
    exp[3] = {1'b0, pg[7:0]}; exp[4] = {1'b0, pg[15:8]}; exp[5] = {1'b0, pg[23:16]};
    exp[6] = {1'b1, 8'h30};
    chk(ncmd == 7, "R1", "command byte count", ncmd, 7);
    for (int i = 0; i < 7; i++) if (cmdlog[i] !== exp[i]) bad++;
    chk(bad == 0, "R1", "command bytes mismatching", bad, 0);
  endtask

  task automatic check_decoded(input string tag);
    int bad = 0, first = -1;
    for (int s = 0; s < 4; s++) begin
      for (int i = 0; i < 512; i++)
        if (got[s*512+i] !== pat(s*528+i)) begin bad++; if (first < 0) first = s*512+i; end
      for (int j = 0; j < 6; j++)
        if (got[2048+s*6+j] !== pat(s*528+512+j)) begin bad++; if (first < 0) first = 2048+s*6+j; end
      for (int k = 0; k < 10; k++)
        if (got[2048+24+s*10+k] !== pat(s*528+518+k)) begin bad++; if (first < 0) first = 2072+s*10+k; end
    end
    chk(nout == PAGE, "R3", "output byte count", nout, PAGE);
    chk(bad == 0, tag, "payload/spare bytes wrong (first index in actual)", first, -1);
    chk(nlast == 1 && lastpos == PAGE-1, "R3", "last marker position", lastpos, PAGE-1);
  endtask

  task automatic t_reset();
    do_reset(0, 0);
    chk(!busy, "R8", "busy after reset", int'(busy), 0);
    chk(!done, "R8", "done after reset", int'(done), 0);
    chk(!dev_valid, "R1", "dev_valid after reset", int'(dev_valid), 0);
    chk(!rd_ready && !out_valid, "R2", "streams idle after reset", int'(rd_ready | out_valid), 0);
  endtask

  task automatic t_clean();
    logic [2:0] em; bit fl;
    do_reset(1, 0);
    run_page(0, 24'h012345, em, fl);
    check_cmds(24'h012345);
    check_decoded("R2");
    chk(ndec == 4, "R10", "decode requests", ndec, 4);
    chk(em == 0, "R4", "err_max clean page", int'(em), 0);
    chk(fl == 0, "R5", "fail clean page", int'(fl), 0);
  endtask

  task automatic t_errs();
    logic [2:0] em; bit fl;
    do_reset(7, 1);
    dstat[0] = 8'h18; dstat[1] = 8'h00; dstat[2] = 8'h38; dstat[3] = 8'h08;
    run_page(0, 24'h00F00D, em, fl);
    check_decoded("R9");
    chk(em == 4, "R4", "err_max with 2,0,4,1", int'(em), 4);
    chk(fl == 0, "R4", "fail with correctable errors", int'(fl), 0);
    do_reset(9, 0);
    dstat[0] = 8'h08; dstat[1] = 8'h28; dstat[2] = 8'h30; dstat[3] = 8'h00;
    run_page(0, 24'h000001, em, fl);
    chk(em == 3, "R4", "err_max with 1,3,flag-clear,0", int'(em), 3);
  endtask

  task automatic t_uncorr();
    logic [2:0] em; bit fl;
    do_reset(3, 0);
    dstat[0] = 8'h18; dstat[1] = 8'h40;
    run_page(0, 24'h123456, em, fl);
    repeat (20) @(negedge clk);
    chk(fl == 1, "R5", "fail on uncorrectable", int'(fl), 1);
    chk(em == 2, "R5", "err_max before abort", int'(em), 2);
    chk(ndec == 2, "R5", "decode requests after abort", ndec, 2);
    chk(nout == 512, "R5", "bytes forwarded before abort", nout, 512);
  endtask

  task automatic t_timeout();
    logic [2:0] em; bit fl;
    do_reset(5, 0);
    dhang[2] = 1;
    run_page(0, 24'h00ABCD, em, fl);
    chk(fl == 1, "R6", "fail on decoder timeout", int'(fl), 1);
    chk(ndec == 3, "R6", "decode requests before timeout", ndec, 3);
    chk(nout == 1024, "R6", "bytes before timeout", nout, 1024);
    do_reset(6, 0);
    for (int i = 0; i < 4; i++) ddel[i] = TMO - 2;
    run_page(0, 24'h00ABCD, em, fl);
    chk(fl == 0, "R6", "late but in-window replies", int'(fl), 0);
    chk(nout == PAGE, "R6", "full page with late replies", nout, PAGE);
  endtask

  task automatic t_raw();
    logic [2:0] em; bit fl;
    int bad = 0, first = -1;
    do_reset(11, 1);
    dstat[0] = 8'h40;
    run_page(1, 24'hABCDEF, em, fl);
    check_cmds(24'hABCDEF);
    for (int t = 0; t < PAGE; t++) if (got[t] !== pat(t)) begin bad++; if (first < 0) first = t; end
    chk(nout == PAGE, "R7", "raw byte count", nout, PAGE);
    chk(bad == 0, "R7", "raw bytes wrong (first index in actual)", first, -1);
    chk(nlast == 1 && lastpos == PAGE-1, "R7", "raw last marker", lastpos, PAGE-1);
    chk(ndec == 0, "R7", "no decode in raw", ndec, 0);
    chk(fl == 0 && em == 0, "R7", "raw status", int'({fl, em}), 0);
  endtask

  initial begin
    t_reset();
    t_clean();
    t_errs();
    t_uncorr();
    t_timeout();
    t_raw();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(negedge clk);
    failures++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule